// File: doc/BRIEF.md
# Receive Buffer Credit Pause Controller

This block tracks how many free receive buffers software has handed to each receive channel and asks the traffic source to pause when that stock runs low. A single context serves each pair of channels (pair index = channel number >> 1). Only the even, receive member of the pair uses the context. Software returns buffers by writing a count to a per-pair allocation register. The receive descriptor engine reports every buffer it fills with a one-cycle `buf_used` pulse on that pair's lane.

Each pair keeps a saturating credit counter. It also keeps a low and a high threshold, which software usually sets to one third and two thirds of the ring size. A pause state with hysteresis sits between the two thresholds. Bit 31 of the allocation register forces the context into a paused, empty condition. Software writes it when it disables the channel. A global configuration word holds a controller enable and one flow-control enable per pair. Both gate the pause outputs. Register access uses a single-cycle write strobe and a combinational read path.

Top module: `rx_pause_ctrl`

## Requirements
- R1: After reset every threshold, credit, force flag and pause state is zero, the configuration word reads 0 and every `pause` bit is low.
- R2: Register map (byte addresses): 0x00 is the configuration word. For pair p, 0x04+12p is the low threshold, 0x08+12p is the high threshold and 0x0C+12p is the allocation register. Thresholds occupy bits [CREDIT_W-1:0] and read back as written. The allocation register reads {force flag in bit 31, zeros, credit in bits [CREDIT_W-1:0]}. Unmapped addresses read 0.
- R3: A write of value N (bits [30:0]) with bit 31 clear to a pair's allocation register adds N to its credit, which saturates at 2^CREDIT_W-1. The new credit is visible after the write's clock edge.
- R4: A `buf_used` pulse lowers that pair's credit by one, never below zero. An allocation write and a pulse in the same cycle are both applied: credit becomes clamp(credit+N-1).
- R5: When the updated credit is below the low threshold, the pair's pause state is set on that clock edge.
- R6: The pause state clears when the updated credit is at or above the high threshold. Between the thresholds it holds its value. If both conditions are true, setting wins.
- R7: An allocation write with bit 31 set sets the force flag, clears credit to zero and sets the pause state. While forced, `buf_used` pulses are ignored. A later allocation write with bit 31 clear removes the force and restarts counting from zero plus N.
- R8: `pause[p]` = pause state of p AND configuration bit 0 (controller enable) AND configuration bit p+1 (pair enable). Credit and pause state keep updating while the output is gated.
- R9: Pairs are independent: a pulse or register write aimed at one pair changes no other pair's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| buf_used | input | NUM_PAIRS | One-cycle pulse per buffer consumed, one lane per pair |
| pause | output | NUM_PAIRS | Pause request per pair |

## Verification
The bench builds the block with two pairs and a 4-bit credit counter. With a counter that narrow, a few allocation writes reach the upper clamp at 15, and a few pulses reach the lower clamp at zero. Random traffic therefore crosses both clamps and both thresholds many times. Two pairs are enough to show that a write or pulse on one lane leaves the other lane untouched. Random writes to the configuration word exercise all four combinations of the global enable and the pair enables.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
    localparam int unsigned REG_CFG_ADDR    = 0;
    localparam int unsigned PAIR_BASE_ADDR  = 4;
    localparam int unsigned PAIR_STRIDE     = 12;
    localparam int unsigned OFS_LOW         = 0;
    localparam int unsigned OFS_HIGH        = 4;
    localparam int unsigned OFS_ALLOC       = 8;
    localparam int unsigned FORCE_BIT       = 31;

    function automatic int unsigned pair_reg_addr(input int unsigned pair, input int unsigned ofs);
        return PAIR_BASE_ADDR + PAIR_STRIDE * pair + ofs;
    endfunction
endpackage

// File: rtl/rx_pause_regs.sv
module rx_pause_regs
    import rx_pause_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 4,
    parameter int unsigned CREDIT_W  = 8,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [NUM_PAIRS:0]                 cfg_wdata,
    input  logic [NUM_PAIRS-1:0][CREDIT_W-1:0] low_rd,
    input  logic [NUM_PAIRS-1:0][CREDIT_W-1:0] high_rd,
    input  logic [NUM_PAIRS-1:0][CREDIT_W-1:0] credit_rd,
    input  logic [NUM_PAIRS-1:0]               force_rd,
    output logic [NUM_PAIRS:0]                 cfg_q,
    output logic [NUM_PAIRS-1:0]               wr_low,
    output logic [NUM_PAIRS-1:0]               wr_high,
    output logic [NUM_PAIRS-1:0]               wr_alloc,
    output logic [31:0]                        reg_rdata
);
    localparam int unsigned CFG_W = NUM_PAIRS + 1;

    logic [NUM_PAIRS-1:0] hit_low, hit_high, hit_alloc;
    logic                 hit_cfg;
    logic [CFG_W-1:0]     cfg_d;

    assign hit_cfg = (reg_addr == ADDR_W'(REG_CFG_ADDR));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_decode
        assign hit_low[p]   = (reg_addr == ADDR_W'(pair_reg_addr(p, OFS_LOW)));
        assign hit_high[p]  = (reg_addr == ADDR_W'(pair_reg_addr(p, OFS_HIGH)));
        assign hit_alloc[p] = (reg_addr == ADDR_W'(pair_reg_addr(p, OFS_ALLOC)));
        assign wr_low[p]    = reg_wr && hit_low[p];
        assign wr_high[p]   = reg_wr && hit_high[p];
        assign wr_alloc[p]  = reg_wr && hit_alloc[p];
    end

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && hit_cfg) begin
            cfg_d = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_cfg) begin
            reg_rdata[CFG_W-1:0] = cfg_q;
        end
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (hit_low[p]) begin
                reg_rdata[CREDIT_W-1:0] = low_rd[p];
            end
            if (hit_high[p]) begin
                reg_rdata[CREDIT_W-1:0] = high_rd[p];
            end
            if (hit_alloc[p]) begin
                reg_rdata[CREDIT_W-1:0] = credit_rd[p];
                reg_rdata[FORCE_BIT]    = force_rd[p];
            end
        end
    end
endmodule

// File: rtl/rx_pause_pair.sv
module rx_pause_pair #(
    parameter int unsigned CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_low,
    input  logic                wr_high,
    input  logic                wr_alloc,
    input  logic [31:0]         wdata,
    input  logic                buf_used,
    output logic [CREDIT_W-1:0] low_q,
    output logic [CREDIT_W-1:0] high_q,
    output logic [CREDIT_W-1:0] credit_q,
    output logic                force_q,
    output logic                paused_q
);
    localparam logic [31:0] CREDIT_MAX = 32'((64'd1 << CREDIT_W) - 64'd1);

    typedef struct packed {
        logic [CREDIT_W-1:0] low;
        logic [CREDIT_W-1:0] high;
        logic [CREDIT_W-1:0] credit;
        logic                force_on;
        logic                paused;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic [31:0] sum;

    always_comb begin
        ctx_d = ctx_q;
        sum   = {{(32-CREDIT_W){1'b0}}, ctx_q.credit};
        if (wr_low) begin
            ctx_d.low = wdata[CREDIT_W-1:0];
        end
        if (wr_high) begin
            ctx_d.high = wdata[CREDIT_W-1:0];
        end
        if (wr_alloc) begin
            ctx_d.force_on = wdata[31];
            if (!wdata[31]) begin
                sum = sum + {1'b0, wdata[30:0]};
            end
        end
        if (buf_used && sum != 32'd0) begin
            sum = sum - 32'd1;
        end
        if (sum > CREDIT_MAX) begin
            sum = CREDIT_MAX;
        end
        if (ctx_d.force_on) begin
            ctx_d.credit = '0;
            ctx_d.paused = 1'b1;
        end else begin
            ctx_d.credit = sum[CREDIT_W-1:0];
            if (ctx_d.credit < ctx_d.low) begin
                ctx_d.paused = 1'b1;
            end else if (ctx_d.credit >= ctx_d.high) begin
                ctx_d.paused = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign low_q    = ctx_q.low;
    assign high_q   = ctx_q.high;
    assign credit_q = ctx_q.credit;
    assign force_q  = ctx_q.force_on;
    assign paused_q = ctx_q.paused;

    p_force_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.force_on |-> (ctx_q.credit == '0 && ctx_q.paused));

    p_used_decrements_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_alloc && buf_used && !ctx_q.force_on && ctx_q.credit != '0)
        |=> (32'(ctx_q.credit) + 32'd1 == 32'($past(ctx_q.credit))));

    p_floor_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_alloc && buf_used && ctx_q.credit == '0) |=> (ctx_q.credit == '0));

    p_set_below_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctx_q.paused) |-> (ctx_q.force_on || ctx_q.credit < ctx_q.low));

    p_clear_at_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctx_q.paused) |-> (ctx_q.credit >= ctx_q.high && ctx_q.credit >= ctx_q.low));
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
    import rx_pause_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 4,
    parameter int unsigned CREDIT_W  = 8,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_PAIRS-1:0] buf_used,
    output logic [NUM_PAIRS-1:0] pause
);
    logic [NUM_PAIRS:0]                 cfg_q;
    logic [NUM_PAIRS-1:0]               wr_low, wr_high, wr_alloc;
    logic [NUM_PAIRS-1:0][CREDIT_W-1:0] low_rd, high_rd, credit_rd;
    logic [NUM_PAIRS-1:0]               force_rd, paused;

    rx_pause_regs #(
        .NUM_PAIRS (NUM_PAIRS),
        .CREDIT_W  (CREDIT_W),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .cfg_wdata (reg_wdata[NUM_PAIRS:0]),
        .low_rd    (low_rd),
        .high_rd   (high_rd),
        .credit_rd (credit_rd),
        .force_rd  (force_rd),
        .cfg_q     (cfg_q),
        .wr_low    (wr_low),
        .wr_high   (wr_high),
        .wr_alloc  (wr_alloc),
        .reg_rdata (reg_rdata)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        rx_pause_pair #(
            .CREDIT_W (CREDIT_W)
        ) pair_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_low   (wr_low[p]),
            .wr_high  (wr_high[p]),
            .wr_alloc (wr_alloc[p]),
            .wdata    (reg_wdata),
            .buf_used (buf_used[p]),
            .low_q    (low_rd[p]),
            .high_q   (high_rd[p]),
            .credit_q (credit_rd[p]),
            .force_q  (force_rd[p]),
            .paused_q (paused[p])
        );

        assign pause[p] = paused[p] && cfg_q[0] && cfg_q[p+1];
    end
endmodule

// File: tb/rx_pause_ctrl_tb_top.sv
module rx_pause_ctrl_tb_top;
    localparam int NP   = 2;
    localparam int CW   = 4;
    localparam int AW   = 8;
    localparam int MAXC = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] buf_used = '0;
    logic [NP-1:0] pause;

    int n_checks = 0;
    int n_fail   = 0;

    int m_cfg;
    int m_low[NP], m_high[NP], m_credit[NP];
    bit m_force[NP], m_paused[NP];

    always #5 clk = ~clk;

    rx_pause_ctrl #(.NUM_PAIRS(NP), .CREDIT_W(CW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_used(buf_used), .pause(pause)
    );

    function automatic int a_low(int p);   return 4 + 12 * p; endfunction
    function automatic int a_high(int p);  return 8 + 12 * p; endfunction
    function automatic int a_alloc(int p); return 12 + 12 * p; endfunction

    function automatic bit exp_pause(int p);
        return m_paused[p] && m_cfg[0] && m_cfg[p+1];
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_step(bit wr, int addr, logic [31:0] data, logic [NP-1:0] used);
        if (wr && addr == 0) m_cfg = int'(data[NP:0]);
        for (int p = 0; p < NP; p++) begin
            longint s;
            bit walloc;
            walloc = wr && addr == a_alloc(p);
            if (wr && addr == a_low(p))  m_low[p]  = int'(data[CW-1:0]);
            if (wr && addr == a_high(p)) m_high[p] = int'(data[CW-1:0]);
            s = m_credit[p];
            if (walloc) begin
                m_force[p] = data[31];
                if (!data[31]) s = s + longint'(data[30:0]);
            end
            if (used[p] && s > 0) s = s - 1;
            if (s > MAXC) s = MAXC;
            if (m_force[p]) begin
                m_credit[p] = 0;
                m_paused[p] = 1;
            end else begin
                m_credit[p] = int'(s);
                if (m_credit[p] < m_low[p]) m_paused[p] = 1;
                else if (m_credit[p] >= m_high[p]) m_paused[p] = 0;
            end
        end
    endtask

    // one clock: drive at negedge, model advances, compare pause at next negedge
    task automatic cyc(bit wr, int addr, logic [31:0] data, logic [NP-1:0] used, string req);
        reg_wr = wr; reg_addr = AW'(addr); reg_wdata = data; buf_used = used;
        model_step(wr, addr, data, used);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; buf_used = '0;
        for (int p = 0; p < NP; p++) check(req, pause[p], exp_pause(p));
    endtask

    task automatic rd(int addr, longint exp, string req);
        reg_wr = 1'b0; reg_addr = AW'(addr);
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic longint alloc_view(int p);
        return (longint'(m_force[p]) << 31) | longint'(m_credit[p]);
    endfunction

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_cfg = 0;
        for (int p = 0; p < NP; p++) begin
            m_low[p] = 0; m_high[p] = 0; m_credit[p] = 0; m_force[p] = 0; m_paused[p] = 0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 0, "R1 cfg");
        rd(a_low(0), 0, "R1 low");
        rd(a_alloc(1), 0, "R1 alloc");
        check("R1 pause", pause, 0);
        rd(100, 0, "R2 unmapped");

        // R2 programming and readback
        cyc(1, a_low(0), 32'hFFFF_FFF2, '0, "R2");
        cyc(1, a_high(0), 32'd4, '0, "R2");
        cyc(1, 0, 32'b011, '0, "R8");
        rd(a_low(0), 2, "R2 low readback");
        rd(a_high(0), 4, "R2 high readback");
        rd(0, 3, "R2 cfg readback");

        // R5/R6 hysteresis
        cyc(1, a_alloc(0), 32'd1, '0, "R5");
        check("R5 pause below low", pause[0], 1);
        cyc(1, a_alloc(0), 32'd2, '0, "R6");
        check("R6 hold between", pause[0], 1);
        cyc(1, a_alloc(0), 32'd1, '0, "R6");
        check("R6 clear at high", pause[0], 0);
        cyc(0, 0, 0, 2'b01, "R6");
        cyc(0, 0, 0, 2'b01, "R6");
        check("R6 hold at low", pause[0], 0);
        cyc(0, 0, 0, 2'b01, "R5");
        check("R5 set under low", pause[0], 1);

        // R4 floor and simultaneous update
        cyc(0, 0, 0, 2'b01, "R4"); cyc(0, 0, 0, 2'b01, "R4"); cyc(0, 0, 0, 2'b01, "R4");
        rd(a_alloc(0), 0, "R4 floor at zero");
        cyc(1, a_alloc(0), 32'd5, 2'b01, "R4");
        rd(a_alloc(0), 4, "R4 alloc and used together");

        // R3 saturation at top
        cyc(1, a_alloc(0), 32'd15, '0, "R3");
        rd(a_alloc(0), 15, "R3 clamp at max");
        cyc(1, a_alloc(0), 32'h7FFF_FFFF, '0, "R3");
        rd(a_alloc(0), 15, "R3 clamp large N");

        // R7 force
        cyc(1, a_alloc(0), 32'h8000_0005, '0, "R7");
        rd(a_alloc(0), 64'h8000_0000, "R7 forced readback");
        check("R7 forced pause", pause[0], 1);
        cyc(0, 0, 0, 2'b01, "R7");
        rd(a_alloc(0), 64'h8000_0000, "R7 used ignored");
        cyc(1, a_alloc(0), 32'd3, '0, "R7");
        rd(a_alloc(0), 3, "R7 release restarts");

        // R8 gating
        cyc(1, 0, 32'b001, '0, "R8");
        cyc(0, 0, 0, 2'b01, "R8");
        check("R8 pair disabled gates", pause[0], 0);
        rd(a_alloc(0), 2, "R8 accounting continues");
        cyc(1, 0, 32'b110, '0, "R8");
        check("R8 global disabled gates", pause[0], 0);
        cyc(1, 0, 32'b111, '0, "R8");
        check("R8 enabled shows state", pause[0], 1);

        // R9 independence
        cyc(1, a_alloc(1), 32'd7, 2'b10, "R9");
        rd(a_alloc(0), 2, "R9 pair0 untouched");
        rd(a_alloc(1), 6, "R9 pair1 updated");
        rd(a_low(1), 0, "R9 pair1 low untouched");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel, p, a;
            logic [31:0] d;
            bit w;
            sel = int'($urandom_range(0, 9));
            p = int'($urandom_range(0, NP - 1));
            w = (sel < 5);
            d = 32'($urandom_range(0, 6));
            case (sel)
                0: a = a_low(p);
                1: a = a_high(p);
                2: a = a_alloc(p);
                3: begin a = a_alloc(p); d = ($urandom_range(0, 7) == 0) ? 32'h8000_0000 : d; end
                4: begin a = 0; d = 32'($urandom_range(0, 7)); end
                default: a = 0;
            endcase
            if (sel == 1) d = 32'($urandom_range(0, MAXC));
            if (sel == 0) d = 32'($urandom_range(0, 8));
            cyc(w, a, d, NP'($urandom_range(0, 3)), "R5 R6 random");
            if (i % 16 == 0) begin
                for (int q = 0; q < NP; q++) begin
                    rd(a_alloc(q), alloc_view(q), "R3 R4 R7 random credit");
                    rd(a_low(q), m_low[q], "R2 random low");
                    rd(a_high(q), m_high[q], "R2 random high");
                end
                rd(0, m_cfg, "R8 random cfg");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule